// File: doc/BRIEF.md
# Processor Bus Error Signaling Unit

This block sits in a host bridge between the bridge's internal error detectors and the processor bus. It turns internal error pulses into the two error indications a processor understands. The first is a machine-check request. It is a level signal that stays high until the processor shows it has taken the exception, which it does by reading one of the fixed machine-check vector addresses. The second is a transfer-error acknowledge. This is a single-clock strobe that aborts the data tenure in progress, even in the middle of a burst.

Each indication has its own enable bit. The transfer-error path tracks how many beats of the current tenure are still owed. When the transfer-error indication is disabled and a data error is reported, the block does not abort. It instead finishes the tenure by driving ordinary transfer acknowledges for every beat that is still outstanding. During normal beats, the data path's own beat acknowledges pass through the block to the bus.

Top module: `pbus_err_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `mchk_o`, `terr_o` and `ta_o` are all 0.
- R2: Any bit of `fatal_evt_i` high while `mchk_en_i` is 1 sets `mchk_o` to 1 from the next cycle. When `mchk_en_i` is 0, fatal events leave `mchk_o` at 0.
- R3: Once set, `mchk_o` stays 1 until a cycle in which `rd_strobe_i` is 1 and `rd_addr_i` equals 32'h0000_0200 or 32'hFFF0_0200. It is 0 from the following cycle. Reads of other addresses, and a vector address presented without the strobe, do not clear it.
- R4: Fatal events that arrive while `mchk_o` is already 1 are absorbed. A single vector read clears `mchk_o`, and it stays 0 afterwards.
- R5: A fatal event (with the enable set) in the same cycle as a vector read keeps `mchk_o` at 1. The new event takes priority over the acknowledge.
- R6: With `terr_en_i` = 1, a `data_err_i` pulse during an active tenure while `dbusy_i` is 1 raises `terr_o` in the next cycle, for exactly one clock.
- R7: A transfer error ends the tenure at once, even mid-burst. `ta_o` stays 0 in the error cycle, in the `terr_o` cycle, and afterwards until a new tenure starts, whatever `beat_ack_i` does.
- R8: With `terr_en_i` = 0, a data error never raises `terr_o`. Instead `ta_o` is 1 on consecutive cycles starting the cycle after the error, once for every beat not yet acknowledged (the erroring beat included). `beat_ack_i` is ignored during these cycles.
- R9: A tenure starts on a rising edge of `dbusy_i` and lasts 4 beats when `burst_i` = 1, or 1 beat when `burst_i` = 0. During the tenure `ta_o` follows `beat_ack_i` in the same cycle. After the last beat, further `beat_ack_i` pulses do not reach `ta_o`.
- R10: A `data_err_i` pulse outside an active tenure has no effect on `terr_o` or `ta_o`.
- R11: A `beat_ack_i` in the same cycle as a data error is not passed to `ta_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mchk_en_i | input | 1 | Enable for the machine-check request |
| terr_en_i | input | 1 | Enable for the transfer-error strobe |
| fatal_evt_i | input | FATAL_SRCS (2) | Nonrecoverable error pulses, one per source |
| data_err_i | input | 1 | Data transfer error pulse |
| dbusy_i | input | 1 | Data bus busy; its rising edge opens a tenure |
| burst_i | input | 1 | 1 = 4-beat burst, 0 = single beat; sampled at tenure start |
| beat_ack_i | input | 1 | Beat acknowledge from the bridge data path |
| rd_addr_i | input | ADDR_W (32) | Address of a processor read |
| rd_strobe_i | input | 1 | Qualifies `rd_addr_i` as a processor read |
| mchk_o | output | 1 | Machine-check request, level |
| terr_o | output | 1 | Transfer-error acknowledge, one-clock strobe |
| ta_o | output | 1 | Transfer acknowledge toward the processor bus |

## Verification
Two pairs of functions can land in the same cycle, and each collision is provoked on purpose.

The first pair is the setting and the clearing of the machine-check request. The bench raises `mchk_o`, then presents a fatal event and a vector read in one cycle. It expects `mchk_o` to remain high, and then expects a lone vector read to clear it.

The second pair is the normal beat acknowledge and a data error. `beat_ack_i` and `data_err_i` are driven together mid-burst, under both settings of the transfer-error enable. The bench expects `ta_o` low in that cycle. It then expects either a single `terr_o` strobe with no further acknowledges, or exactly the number of completion acknowledges still owed.

// File: rtl/pbus_err_pkg.sv
package pbus_err_pkg;

   // Tenure tracking state of the transfer-error path
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,   // no tenure open
      XS_XFER = 2'd1,   // beats pass through from the data path
      XS_TERM = 2'd2,   // transfer-error strobe cycle
      XS_FILL = 2'd3    // completing the tenure with forced acknowledges
   } xfer_state_e;

   // Width of a down-counter that must hold values 0 .. beats-1
   function automatic int unsigned beat_cnt_width(input int unsigned beats);
      return (beats > 1) ? $clog2(beats) : 1;
   endfunction

endpackage

// File: rtl/pbus_vec_match.sv
module pbus_vec_match #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned NUM_VEC  = 2,
   parameter logic [NUM_VEC*ADDR_W-1:0] VEC_LIST = {32'hFFF0_0200, 32'h0000_0200}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   output logic              hit_o
);

   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("pbus_vec_match: ADDR_W must be at least 12");
   end
   if (NUM_VEC < 1) begin : g_bad_num_vec
      $error("pbus_vec_match: NUM_VEC must be at least 1");
   end

   logic [NUM_VEC-1:0] match;

   // One comparator for each vector in the list
   for (genvar g = 0; g < NUM_VEC; g++) begin : g_cmp
      assign match[g] = (addr_i == VEC_LIST[g*ADDR_W +: ADDR_W]);
   end

   assign hit_o = rd_i & (|match);

   // R3
   hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> rd_i);

endmodule

// File: rtl/pbus_mchk_ctrl.sv
module pbus_mchk_ctrl #(
   parameter int unsigned FATAL_SRCS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_i,
   input  logic [FATAL_SRCS-1:0] evt_i,
   input  logic                  ack_i,
   output logic                  mchk_o
);

   if (FATAL_SRCS < 1) begin : g_bad_srcs
      $error("pbus_mchk_ctrl: FATAL_SRCS must be at least 1");
   end

   logic set_req;
   logic mchk_q;

   assign set_req = en_i & (|evt_i);

   // A new event outranks a concurrent acknowledge; repeats are absorbed
   always_ff @(posedge clk) begin
      if (!rst_n)       mchk_q <= 1'b0;
      else if (set_req) mchk_q <= 1'b1;
      else if (ack_i)   mchk_q <= 1'b0;
   end

   assign mchk_o = mchk_q;

   // R2
   mchk_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mchk_o) |-> $past(en_i && (|evt_i)));

   // R3
   mchk_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mchk_o) |-> $past(ack_i));

   // R5
   mchk_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mchk_o && en_i && (|evt_i) && ack_i) |=> mchk_o);

   // R4
   mchk_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mchk_o && !ack_i) |=> mchk_o);

endmodule

// File: rtl/pbus_xfer_ctrl.sv
module pbus_xfer_ctrl
   import pbus_err_pkg::*;
#(
   parameter int unsigned BURST_BEATS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic terr_en_i,
   input  logic data_err_i,
   input  logic dbusy_i,
   input  logic burst_i,
   input  logic beat_ack_i,
   output logic terr_o,
   output logic ta_o
);

   localparam int unsigned CNT_W = beat_cnt_width(BURST_BEATS);
   localparam logic [CNT_W-1:0] LAST_BURST = CNT_W'(BURST_BEATS - 1);

   if (BURST_BEATS < 2) begin : g_bad_beats
      $error("pbus_xfer_ctrl: BURST_BEATS must be at least 2");
   end

   xfer_state_e      state_q, state_d;
   logic [CNT_W-1:0] rem_q, rem_d;   // beats still owed, minus one
   logic             dbusy_q;
   logic             start;
   logic             err_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) dbusy_q <= 1'b0;
      else        dbusy_q <= dbusy_i;
   end

   assign start   = dbusy_i & ~dbusy_q;
   assign err_hit = (state_q == XS_XFER) & dbusy_i & data_err_i;

   always_comb begin
      state_d = state_q;
      rem_d   = rem_q;
      unique case (state_q)
         XS_IDLE: begin
            if (start) begin
               state_d = XS_XFER;
               rem_d   = burst_i ? LAST_BURST : '0;
            end
         end
         XS_XFER: begin
            if (err_hit) begin
               state_d = terr_en_i ? XS_TERM : XS_FILL;
            end else if (beat_ack_i) begin
               if (rem_q == '0) state_d = XS_IDLE;
               else             rem_d   = rem_q - 1'b1;
            end
         end
         XS_TERM: state_d = XS_IDLE;
         XS_FILL: begin
            if (rem_q == '0) state_d = XS_IDLE;
            else             rem_d   = rem_q - 1'b1;
         end
         default: state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         rem_q   <= '0;
      end else begin
         state_q <= state_d;
         rem_q   <= rem_d;
      end
   end

   assign terr_o = (state_q == XS_TERM);
   assign ta_o   = (state_q == XS_FILL) |
                   ((state_q == XS_XFER) & beat_ack_i & ~err_hit);

   // R6
   terr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr_o |-> $past(dbusy_i && terr_en_i && data_err_i));

   // R6
   terr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr_o |=> !terr_o);

   // R7
   terr_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      terr_o |-> (!ta_o ##1 !ta_o));

   // R8
   fill_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_hit && !terr_en_i) |=> (ta_o && !terr_o));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XS_IDLE) |-> (!ta_o && !terr_o));

endmodule

// File: rtl/pbus_err_unit.sv
module pbus_err_unit #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned FATAL_SRCS  = 2,
   parameter int unsigned BURST_BEATS = 4,
   parameter int unsigned NUM_VEC     = 2,
   parameter logic [NUM_VEC*ADDR_W-1:0] VEC_LIST = {32'hFFF0_0200, 32'h0000_0200}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mchk_en_i,
   input  logic                  terr_en_i,
   input  logic [FATAL_SRCS-1:0] fatal_evt_i,
   input  logic                  data_err_i,
   input  logic                  dbusy_i,
   input  logic                  burst_i,
   input  logic                  beat_ack_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   input  logic                  rd_strobe_i,
   output logic                  mchk_o,
   output logic                  terr_o,
   output logic                  ta_o
);

   logic vec_hit;

   pbus_vec_match #(
      .ADDR_W   (ADDR_W),
      .NUM_VEC  (NUM_VEC),
      .VEC_LIST (VEC_LIST)
   ) u_vec (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (rd_addr_i),
      .rd_i   (rd_strobe_i),
      .hit_o  (vec_hit)
   );

   pbus_mchk_ctrl #(
      .FATAL_SRCS (FATAL_SRCS)
   ) u_mchk (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (mchk_en_i),
      .evt_i  (fatal_evt_i),
      .ack_i  (vec_hit),
      .mchk_o (mchk_o)
   );

   pbus_xfer_ctrl #(
      .BURST_BEATS (BURST_BEATS)
   ) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .terr_en_i  (terr_en_i),
      .data_err_i (data_err_i),
      .dbusy_i    (dbusy_i),
      .burst_i    (burst_i),
      .beat_ack_i (beat_ack_i),
      .terr_o     (terr_o),
      .ta_o       (ta_o)
   );

endmodule

// File: tb/sim_pbus_err_unit.sv
`timescale 1ns/1ps
module sim_pbus_err_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mchk_en_i = 1'b0;
   logic        terr_en_i = 1'b0;
   logic [1:0]  fatal_evt_i = '0;
   logic        data_err_i = 1'b0;
   logic        dbusy_i = 1'b0;
   logic        burst_i = 1'b0;
   logic        beat_ack_i = 1'b0;
   logic [31:0] rd_addr_i = '0;
   logic        rd_strobe_i = 1'b0;
   logic        mchk_o, terr_o, ta_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pbus_err_unit u0 (
      .clk(clk), .rst_n(rst_n), .mchk_en_i(mchk_en_i), .terr_en_i(terr_en_i),
      .fatal_evt_i(fatal_evt_i), .data_err_i(data_err_i), .dbusy_i(dbusy_i),
      .burst_i(burst_i), .beat_ack_i(beat_ack_i), .rd_addr_i(rd_addr_i),
      .rd_strobe_i(rd_strobe_i), .mchk_o(mchk_o), .terr_o(terr_o), .ta_o(ta_o)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
      end
   endtask

   // advance to the next falling edge (registered results are settled there)
   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      fatal_evt_i = '0; data_err_i = 1'b0; beat_ack_i = 1'b0;
      rd_strobe_i = 1'b0; rd_addr_i = '0;
   endtask

   task automatic t_reset();
      mchk_en_i = 1'b1; fatal_evt_i = 2'b11;
      rst_n = 1'b0;
      nxt(); nxt();
      fatal_evt_i = '0;
      rst_n = 1'b1;
      nxt();
      chk(mchk_o, 1'b0, "R1 mchk_o after reset");
      chk(terr_o, 1'b0, "R1 terr_o after reset");
      chk(ta_o,   1'b0, "R1 ta_o after reset");
   endtask

   task automatic t_mchk_basic();
      mchk_en_i = 1'b1; fatal_evt_i = 2'b01;
      nxt(); fatal_evt_i = '0;
      chk(mchk_o, 1'b1, "R2 mchk_o raised by source 0");
      rd_strobe_i = 1'b1; rd_addr_i = 32'h0000_0300;
      nxt(); chk(mchk_o, 1'b1, "R3 non-vector read keeps mchk_o");
      rd_strobe_i = 1'b0; rd_addr_i = 32'h0000_0200;
      nxt(); chk(mchk_o, 1'b1, "R3 vector address without strobe keeps mchk_o");
      rd_strobe_i = 1'b1; rd_addr_i = 32'hFFF0_0200;
      nxt(); idle_inputs();
      chk(mchk_o, 1'b0, "R3 high vector read clears mchk_o");
      fatal_evt_i = 2'b10;
      nxt(); fatal_evt_i = '0;
      chk(mchk_o, 1'b1, "R2 mchk_o raised by source 1");
      rd_strobe_i = 1'b1; rd_addr_i = 32'h0000_0200;
      nxt(); idle_inputs();
      chk(mchk_o, 1'b0, "R3 low vector read clears mchk_o");
   endtask

   task automatic t_mchk_disabled();
      mchk_en_i = 1'b0; fatal_evt_i = 2'b11;
      nxt(); fatal_evt_i = '0;
      chk(mchk_o, 1'b0, "R2 disabled enable blocks mchk_o");
      nxt(); chk(mchk_o, 1'b0, "R2 mchk_o stays low when disabled");
      mchk_en_i = 1'b1;
   endtask

   task automatic t_mchk_absorb();
      fatal_evt_i = 2'b01;
      nxt(); chk(mchk_o, 1'b1, "R4 first event raises mchk_o");
      fatal_evt_i = 2'b10;
      nxt(); fatal_evt_i = 2'b01;
      nxt(); fatal_evt_i = '0;
      chk(mchk_o, 1'b1, "R4 repeated events keep mchk_o");
      rd_strobe_i = 1'b1; rd_addr_i = 32'h0000_0200;
      nxt(); idle_inputs();
      chk(mchk_o, 1'b0, "R4 one acknowledge clears absorbed events");
      nxt(); chk(mchk_o, 1'b0, "R4 no second acknowledge needed");
   endtask

   task automatic t_mchk_set_wins();
      fatal_evt_i = 2'b01;
      nxt(); fatal_evt_i = '0;
      chk(mchk_o, 1'b1, "R5 setup raise");
      fatal_evt_i = 2'b10; rd_strobe_i = 1'b1; rd_addr_i = 32'hFFF0_0200;
      nxt(); idle_inputs();
      chk(mchk_o, 1'b1, "R5 event with acknowledge keeps mchk_o");
      rd_strobe_i = 1'b1; rd_addr_i = 32'hFFF0_0200;
      nxt(); idle_inputs();
      chk(mchk_o, 1'b0, "R5 later acknowledge clears");
   endtask

   task automatic t_burst_ok();
      terr_en_i = 1'b1; burst_i = 1'b1; dbusy_i = 1'b1;
      nxt(); burst_i = 1'b0;   // burst length must be held only at start
      for (int i = 0; i < 4; i++) begin
         beat_ack_i = 1'b1; #2;
         chk(ta_o, 1'b1, $sformatf("R9 burst beat %0d passes", i));
         nxt();
      end
      #2; chk(ta_o, 1'b0, "R9 ack after fourth beat blocked");
      beat_ack_i = 1'b0; dbusy_i = 1'b0;
      nxt();
   endtask

   task automatic t_single_ok();
      burst_i = 1'b0; dbusy_i = 1'b1;
      nxt();
      beat_ack_i = 1'b1; #2;
      chk(ta_o, 1'b1, "R9 single beat passes");
      nxt(); #2;
      chk(ta_o, 1'b0, "R9 ack after single beat blocked");
      beat_ack_i = 1'b0; dbusy_i = 1'b0;
      nxt();
   endtask

   task automatic t_terr_mid();
      terr_en_i = 1'b1; burst_i = 1'b1; dbusy_i = 1'b1;
      nxt();
      beat_ack_i = 1'b1; nxt(); nxt();
      data_err_i = 1'b1; #2;
      chk(ta_o, 1'b0, "R11 ack in error cycle suppressed");
      chk(terr_o, 1'b0, "R6 no strobe in error cycle");
      nxt(); data_err_i = 1'b0;
      chk(terr_o, 1'b1, "R6 terr_o one cycle after error");
      #2; chk(ta_o, 1'b0, "R7 no ack in strobe cycle");
      nxt();
      chk(terr_o, 1'b0, "R6 terr_o lasts one clock");
      #2; chk(ta_o, 1'b0, "R7 tenure ended mid-burst");
      nxt(); #2; chk(ta_o, 1'b0, "R7 still no ack after abort");
      beat_ack_i = 1'b0; dbusy_i = 1'b0;
      nxt();
   endtask

   task automatic t_fill_burst();
      terr_en_i = 1'b0; burst_i = 1'b1; dbusy_i = 1'b1;
      nxt();
      beat_ack_i = 1'b1; nxt();
      data_err_i = 1'b1; #2;
      chk(ta_o, 1'b0, "R11 ack in error cycle suppressed (fill)");
      nxt(); data_err_i = 1'b0; beat_ack_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         #2;
         chk(ta_o, 1'b1, $sformatf("R8 completion ack %0d", i));
         chk(terr_o, 1'b0, "R8 no strobe when disabled");
         nxt();
      end
      beat_ack_i = 1'b1; #2;
      chk(ta_o, 1'b0, "R8 completion stops after owed beats");
      beat_ack_i = 1'b0; dbusy_i = 1'b0;
      nxt();
   endtask

   task automatic t_fill_single();
      terr_en_i = 1'b0; burst_i = 1'b0; dbusy_i = 1'b1;
      nxt();
      data_err_i = 1'b1; #2;
      chk(ta_o, 1'b0, "R11 single error cycle no ack");
      nxt(); data_err_i = 1'b0; #2;
      chk(ta_o, 1'b1, "R8 single completion ack");
      nxt(); #2;
      chk(ta_o, 1'b0, "R8 single completion only once");
      dbusy_i = 1'b0;
      nxt();
   endtask

   task automatic t_err_idle();
      terr_en_i = 1'b1; dbusy_i = 1'b0; data_err_i = 1'b1;
      nxt(); data_err_i = 1'b0;
      chk(terr_o, 1'b0, "R10 error outside tenure no strobe");
      #2; chk(ta_o, 1'b0, "R10 error outside tenure no ack");
      nxt(); chk(terr_o, 1'b0, "R10 still quiet");
   endtask

   initial begin
      nxt();
      t_reset();
      t_mchk_basic();
      t_mchk_disabled();
      t_mchk_absorb();
      t_mchk_set_wins();
      t_burst_ok();
      t_single_ok();
      t_terr_mid();
      t_fill_burst();
      t_fill_single();
      t_err_idle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule